// File: doc/BRIEF.md
# Flow Filter Table Command Engine

The block keeps a small table of flow filters, one slot per hash bucket, and changes it through a register port. Software loads a hash word, a set of match fields and a configuration word. It then writes a command word whose two-bit operation field selects add, query or remove. While that field is non-zero the engine is busy. It carries out the operation over a fixed number of cycles, then clears the field back to zero, which software polls as "done".

An add builds an entry from the command flags (update, last, queue enable, drop), the flow type, the target queue, the pool and the signature bits of the hash word. In perfect-match mode the entry also stores addresses, ports and flex/packet-type bytes. A query reports in the command word whether the addressed slot holds a filter with the same signature, and copies that entry into a read-only result view. A remove takes effect only when the preceding query reported a hit. A flush input empties the whole table at once.

Top module: `flow_cmd_engine`

## Requirements
- R1: After reset every readable address (0 to 15) reads zero, `busy` is low and no slot holds a filter.
- R2: Register map: 0 hash word, 1 command, 2 source address, 3 destination address, 4 ports, 5 flex, 6 configuration, 8 to 13 query result (hash view, control view, source, destination, ports, flex). Other addresses read zero. Hash word: bits [3:0] slot index, bits [23:8] signature, bit 31 valid. Command: [1:0] operation (0 none, 1 add, 2 query, 3 remove), bit 2 update, bit 3 last, bit 4 queue enable, bit 5 drop, bit 6 found (read-only), bit 7 error (read-only), [9:8] flow type, [16:10] queue, [22:17] pool. Configuration: bit 0 perfect mode, [7:1] drop queue. Writing a command with a zero operation only stores its fields.
- R3: After the clock edge that accepts a command write, `busy` and the operation field stay non-zero for exactly two cycles, and both are zero after the third edge.
- R4: An accepted add writes the slot. A later query with the same signature sets found=1. The control view then reads {pool at [22:17], queue at [16:10], flow type at [9:8], drop bit 4, queue enable bit 3, last bit 2, perfect bit 1, valid bit 0}, and the hash view reads valid at bit 31 and the signature at [23:8].
- R5: An add whose hash word has bit 31 clear sets error and leaves the table unchanged.
- R6: An add to an occupied slot with the update flag clear sets error and keeps the old entry. With the update flag set, it overwrites the old entry and clears error.
- R7: A query hits only when the slot is valid and its stored signature equals the hash word's signature. On a miss, found=0 and all six result registers read zero.
- R8: A remove clears the slot only when found=1 from an earlier query. It then clears found and error. When found=0, the remove sets error and changes nothing.
- R9: In perfect mode an add stores the source, destination, ports and flex registers. In signature mode those four fields of the entry are stored as zero.
- R10: An add with the drop flag in perfect mode stores the drop queue from the configuration in place of the command's queue. In signature mode such an add sets error and writes nothing.
- R11: Writes to any address while `busy` is high are ignored.
- R12: A flush empties every slot, clears the operation field, found, error and the result registers, and discards a register write presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the table and return to idle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| busy | output | 1 | Operation field of the command register is non-zero |

## Verification
Two pairs of events can land on the same clock edge. A flush can arrive together with a command write, or while an operation is still in flight. A register write can arrive in the busy window, including on the edge that completes the operation. The bench aims a flush at the cycle that carries a command write and at the middle of an add, and then judges, through the command word and a query, that nothing was stored and the engine is idle. It also writes the hash and command registers on the second and third edges of an add, and then checks that both still hold the earlier values and that the add alone took effect.

// File: rtl/fce_pkg.sv
`timescale 1ns/1ps
package fce_pkg;
  localparam int AW     = 4;
  localparam int DW     = 32;
  localparam int SIG_W  = 16;
  localparam int Q_W    = 7;
  localparam int POOL_W = 6;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_ADD    = 2'd1,
    OP_QUERY  = 2'd2,
    OP_REMOVE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOK   = 2'd1,
    ST_COMMIT = 2'd2
  } st_e;

  localparam logic [AW-1:0] RA_HASH  = 4'd0;
  localparam logic [AW-1:0] RA_CMD   = 4'd1;
  localparam logic [AW-1:0] RA_SIP   = 4'd2;
  localparam logic [AW-1:0] RA_DIP   = 4'd3;
  localparam logic [AW-1:0] RA_PORT  = 4'd4;
  localparam logic [AW-1:0] RA_FLEX  = 4'd5;
  localparam logic [AW-1:0] RA_CFG   = 4'd6;
  localparam logic [AW-1:0] RA_RHASH = 4'd8;
  localparam logic [AW-1:0] RA_RCTL  = 4'd9;
  localparam logic [AW-1:0] RA_RSIP  = 4'd10;
  localparam logic [AW-1:0] RA_RDIP  = 4'd11;
  localparam logic [AW-1:0] RA_RPORT = 4'd12;
  localparam logic [AW-1:0] RA_RFLEX = 4'd13;

  // command word bit positions
  localparam int CB_UPD   = 2;
  localparam int CB_LAST  = 3;
  localparam int CB_QEN   = 4;
  localparam int CB_DROP  = 5;
  localparam int CB_FOUND = 6;
  localparam int CB_ERR   = 7;
  localparam int CB_FT    = 8;
  localparam int CB_Q     = 10;
  localparam int CB_POOL  = 17;
  // hash word bit positions
  localparam int HB_SIG   = 8;
  localparam int HB_VLD   = 31;

  typedef struct packed {
    logic              valid;
    logic              perfect;
    logic              last;
    logic              qen;
    logic              drop;
    logic [1:0]        ftype;
    logic [Q_W-1:0]    queue;
    logic [POOL_W-1:0] pool;
    logic [SIG_W-1:0]  sig;
    logic [DW-1:0]     sip;
    logic [DW-1:0]     dip;
    logic [DW-1:0]     ports;
    logic [DW-1:0]     flex;
  } entry_t;

  // Build a table entry from the software registers.
  function automatic entry_t make_entry(input logic [DW-1:0] hash,
                                        input logic [DW-1:0] cmd,
                                        input logic [DW-1:0] cfg,
                                        input logic [DW-1:0] sip,
                                        input logic [DW-1:0] dip,
                                        input logic [DW-1:0] ports,
                                        input logic [DW-1:0] flex);
    entry_t e;
    logic   pf;
    pf        = cfg[0];
    e.valid   = 1'b1;
    e.perfect = pf;
    e.last    = cmd[CB_LAST];
    e.qen     = cmd[CB_QEN];
    e.drop    = cmd[CB_DROP];
    e.ftype   = cmd[CB_FT +: 2];
    e.queue   = cmd[CB_DROP] ? cfg[1 +: Q_W] : cmd[CB_Q +: Q_W];
    e.pool    = cmd[CB_POOL +: POOL_W];
    e.sig     = hash[HB_SIG +: SIG_W];
    e.sip     = pf ? sip   : '0;
    e.dip     = pf ? dip   : '0;
    e.ports   = pf ? ports : '0;
    e.flex    = pf ? flex  : '0;
    return e;
  endfunction

  // Control view of an entry as seen in the result registers.
  function automatic logic [DW-1:0] ctl_view(input entry_t e);
    logic [DW-1:0] w;
    w                    = '0;
    w[0]                 = e.valid;
    w[1]                 = e.perfect;
    w[2]                 = e.last;
    w[3]                 = e.qen;
    w[4]                 = e.drop;
    w[CB_FT +: 2]        = e.ftype;
    w[CB_Q +: Q_W]       = e.queue;
    w[CB_POOL +: POOL_W] = e.pool;
    return w;
  endfunction

  // Hash view of an entry as seen in the result registers.
  function automatic logic [DW-1:0] hash_view(input entry_t e);
    logic [DW-1:0] w;
    w                    = '0;
    w[HB_VLD]            = e.valid;
    w[HB_SIG +: SIG_W]   = e.sig;
    return w;
  endfunction

  // An add is refused on a clear valid bit, drop outside perfect mode,
  // or an occupied slot without the update flag.
  function automatic logic add_refused(input logic [DW-1:0] hash,
                                       input logic [DW-1:0] cmd,
                                       input logic [DW-1:0] cfg,
                                       input logic          occupied);
    return !hash[HB_VLD] || (cmd[CB_DROP] && !cfg[0]) ||
           (occupied && !cmd[CB_UPD]);
  endfunction
endpackage

// File: rtl/fce_seq.sv
`timescale 1ns/1ps
module fce_seq
  import fce_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic start,
  output logic look,
  output logic commit,
  output logic idle
);
  st_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else if (flush) begin
      st_q <= ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE:   if (start) st_q <= ST_LOOK;
        ST_LOOK:   st_q <= ST_COMMIT;
        ST_COMMIT: st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  assign look   = (st_q == ST_LOOK);
  assign commit = (st_q == ST_COMMIT);
  assign idle   = (st_q == ST_IDLE);

  // R3
  look_to_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    look && !flush |=> commit);
  // R3
  commit_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> idle);
endmodule

// File: rtl/fce_table.sv
`timescale 1ns/1ps
module fce_table
  import fce_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] idx,
  input  entry_t           wr_entry,
  output entry_t           rd_entry,
  output logic [(1<<IDX_W)-1:0] vld_vec
);
  localparam int DEPTH = 1 << IDX_W;

  entry_t slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (flush) begin
        slot_q[g] <= '0;
      end else if (wr_en && idx == IDX_W'(g)) begin
        slot_q[g] <= wr_entry;
      end else if (clr_en && idx == IDX_W'(g)) begin
        slot_q[g] <= '0;
      end
    end
    assign vld_vec[g] = slot_q[g].valid;
  end

  assign rd_entry = slot_q[idx];

  // R12
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> vld_vec == '0);
  // R8
  clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en && !flush |=> !vld_vec[$past(idx)]);
  // R4
  wr_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !flush |=> vld_vec[$past(idx)]);
  // R8
  wr_clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && clr_en));
endmodule

// File: rtl/fce_regs.sv
`timescale 1ns/1ps
module fce_regs
  import fce_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_acc,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          done,
  input  logic          found_d,
  input  logic          err_d,
  input  logic          res_we,
  input  entry_t        res_entry,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] hash_q,
  output logic [DW-1:0] cmd_q,
  output logic [DW-1:0] cfg_q,
  output logic [DW-1:0] sip_q,
  output logic [DW-1:0] dip_q,
  output logic [DW-1:0] port_q,
  output logic [DW-1:0] flex_q
);
  entry_t res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hash_q <= '0;
      cfg_q  <= '0;
      sip_q  <= '0;
      dip_q  <= '0;
      port_q <= '0;
      flex_q <= '0;
    end else if (wr_acc) begin
      case (wr_addr)
        RA_HASH: hash_q <= wr_data;
        RA_CFG:  cfg_q  <= wr_data;
        RA_SIP:  sip_q  <= wr_data;
        RA_DIP:  dip_q  <= wr_data;
        RA_PORT: port_q <= wr_data;
        RA_FLEX: flex_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (flush) begin
      cmd_q[1:0]      <= 2'b00;
      cmd_q[CB_FOUND] <= 1'b0;
      cmd_q[CB_ERR]   <= 1'b0;
    end else if (wr_acc && wr_addr == RA_CMD) begin
      cmd_q <= {wr_data[DW-1:CB_ERR+1], cmd_q[CB_ERR:CB_FOUND], wr_data[CB_FOUND-1:0]};
    end else if (done) begin
      cmd_q[1:0]      <= 2'b00;
      cmd_q[CB_FOUND] <= found_d;
      cmd_q[CB_ERR]   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (flush) begin
      res_q <= '0;
    end else if (res_we) begin
      res_q <= res_entry;
    end
  end

  always_comb begin
    case (rd_addr)
      RA_HASH:  rd_data = hash_q;
      RA_CMD:   rd_data = cmd_q;
      RA_SIP:   rd_data = sip_q;
      RA_DIP:   rd_data = dip_q;
      RA_PORT:  rd_data = port_q;
      RA_FLEX:  rd_data = flex_q;
      RA_CFG:   rd_data = cfg_q;
      RA_RHASH: rd_data = hash_view(res_q);
      RA_RCTL:  rd_data = ctl_view(res_q);
      RA_RSIP:  rd_data = res_q.sip;
      RA_RDIP:  rd_data = res_q.dip;
      RA_RPORT: rd_data = res_q.ports;
      RA_RFLEX: rd_data = res_q.flex;
      default:  rd_data = '0;
    endcase
  end

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_acc |=> $stable(cfg_q) && $stable(hash_q));
endmodule

// File: rtl/flow_cmd_engine.sv
`timescale 1ns/1ps
module flow_cmd_engine
  import fce_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] hash_q, cmd_q, cfg_q, sip_q, dip_q, port_q, flex_q;
  logic          wr_acc, start, look, commit, seq_idle;
  logic          found_d, err_d, res_we, refused, hit;
  logic          tbl_wr, tbl_clr;
  logic [IDX_W-1:0] slot_idx;
  logic [DEPTH-1:0] vld_vec;
  entry_t        tbl_rd, snap_q, new_entry, res_entry;
  op_e           op;

  assign busy     = (cmd_q[1:0] != 2'b00);
  assign wr_acc   = wr_en && !busy && !flush;
  assign start    = wr_acc && (wr_addr == RA_CMD) && (wr_data[1:0] != 2'b00);
  assign slot_idx = hash_q[IDX_W-1:0];
  assign op       = op_e'(cmd_q[1:0]);

  fce_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .start  (start),
    .look   (look),
    .commit (commit),
    .idle   (seq_idle)
  );

  // Slot snapshot taken in the lookup cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    snap_q <= '0;
    else if (look) snap_q <= tbl_rd;
  end

  assign new_entry = make_entry(hash_q, cmd_q, cfg_q, sip_q, dip_q, port_q, flex_q);
  assign refused   = add_refused(hash_q, cmd_q, cfg_q, snap_q.valid);
  assign hit       = snap_q.valid && (snap_q.sig == hash_q[HB_SIG +: SIG_W]);

  always_comb begin
    found_d   = cmd_q[CB_FOUND];
    err_d     = 1'b0;
    tbl_wr    = 1'b0;
    tbl_clr   = 1'b0;
    res_we    = 1'b0;
    res_entry = '0;
    case (op)
      OP_ADD: begin
        err_d  = refused;
        tbl_wr = commit && !refused;
      end
      OP_QUERY: begin
        found_d   = hit;
        res_we    = commit;
        res_entry = hit ? snap_q : '0;
      end
      OP_REMOVE: begin
        found_d = 1'b0;
        err_d   = !cmd_q[CB_FOUND];
        tbl_clr = commit && cmd_q[CB_FOUND];
      end
      default: ;
    endcase
  end

  fce_table #(.IDX_W(IDX_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr_en    (tbl_wr),
    .clr_en   (tbl_clr),
    .idx      (slot_idx),
    .wr_entry (new_entry),
    .rd_entry (tbl_rd),
    .vld_vec  (vld_vec)
  );

  fce_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .wr_acc    (wr_acc),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .done      (commit),
    .found_d   (found_d),
    .err_d     (err_d),
    .res_we    (res_we),
    .res_entry (res_entry),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .hash_q    (hash_q),
    .cmd_q     (cmd_q),
    .cfg_q     (cfg_q),
    .sip_q     (sip_q),
    .dip_q     (dip_q),
    .port_q    (port_q),
    .flex_q    (flex_q)
  );

  // R2
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> seq_idle);
  // R3
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !flush |=> !busy);
  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && !flush |=> busy);
  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en |=> $stable(hash_q) && $stable(sip_q));
  // R5
  add_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr |-> hash_q[HB_VLD]);
  // R10
  drop_perfect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr && new_entry.drop |-> cfg_q[0]);
  // R12
  flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !busy && seq_idle);
endmodule

// File: tb/flow_cmd_engine_bench.sv
`timescale 1ns/1ps
module flow_cmd_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        busy;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flow_cmd_engine u_flow_cmd_engine (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy)
  );

  // reference state
  logic [31:0] r_hash, r_cmd, r_sip, r_dip, r_port, r_flex, r_cfg;
  bit          m_found, m_err;
  logic [31:0] s_h [16];
  logic [31:0] s_c [16];
  logic [31:0] s_s [16];
  logic [31:0] s_d [16];
  logic [31:0] s_p [16];
  logic [31:0] s_f [16];
  logic [31:0] x_h, x_c, x_s, x_d, x_p, x_f;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic model_reset();
    r_hash = 0; r_cmd = 0; r_sip = 0; r_dip = 0; r_port = 0; r_flex = 0; r_cfg = 0;
    m_found = 0; m_err = 0;
    for (int i = 0; i < 16; i++) begin
      s_h[i] = 0; s_c[i] = 0; s_s[i] = 0; s_d[i] = 0; s_p[i] = 0; s_f[i] = 0;
    end
    x_h = 0; x_c = 0; x_s = 0; x_d = 0; x_p = 0; x_f = 0;
  endtask

  task automatic model_flush();
    for (int i = 0; i < 16; i++) begin
      s_h[i] = 0; s_c[i] = 0; s_s[i] = 0; s_d[i] = 0; s_p[i] = 0; s_f[i] = 0;
    end
    m_found = 0; m_err = 0;
    x_h = 0; x_c = 0; x_s = 0; x_d = 0; x_p = 0; x_f = 0;
    r_cmd[1:0] = 2'b00;
  endtask

  // R4 R5 R6 R7 R8 R9 R10: expected effect of the stored command
  task automatic model_op();
    int unsigned b;
    bit          bad, hit, pf;
    logic [6:0]  q;
    b  = r_hash[3:0];
    pf = r_cfg[0];
    case (r_cmd[1:0])
      2'd1: begin
        bad = !r_hash[31] || (r_cmd[5] && !pf) || (s_c[b][0] && !r_cmd[2]);
        m_err = bad;
        if (!bad) begin
          q = r_cmd[5] ? r_cfg[7:1] : r_cmd[16:10];
          s_c[b] = {9'b0, r_cmd[22:17], q, r_cmd[9:8], 3'b000,
                    r_cmd[5], r_cmd[4], r_cmd[3], pf, 1'b1};
          s_h[b] = {1'b1, 7'b0, r_hash[23:8], 8'h00};
          s_s[b] = pf ? r_sip  : 32'h0;
          s_d[b] = pf ? r_dip  : 32'h0;
          s_p[b] = pf ? r_port : 32'h0;
          s_f[b] = pf ? r_flex : 32'h0;
        end
      end
      2'd2: begin
        hit = s_c[b][0] && (s_h[b][23:8] == r_hash[23:8]);
        m_found = hit; m_err = 0;
        x_h = hit ? s_h[b] : 0; x_c = hit ? s_c[b] : 0;
        x_s = hit ? s_s[b] : 0; x_d = hit ? s_d[b] : 0;
        x_p = hit ? s_p[b] : 0; x_f = hit ? s_f[b] : 0;
      end
      2'd3: begin
        if (m_found) begin
          s_h[b] = 0; s_c[b] = 0; s_s[b] = 0; s_d[b] = 0; s_p[b] = 0; s_f[b] = 0;
          m_found = 0; m_err = 0;
        end else begin
          m_err = 1;
        end
      end
      default: ;
    endcase
    r_cmd[1:0] = 2'b00;
  endtask

  function automatic logic [31:0] exp_cmd();
    return {r_cmd[31:8], m_err, m_found, r_cmd[5:2], 2'b00};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      4'd0: r_hash = d;
      4'd2: r_sip  = d;
      4'd3: r_dip  = d;
      4'd4: r_port = d;
      4'd5: r_flex = d;
      4'd6: r_cfg  = d;
      default: ;
    endcase
  endtask

  // Issue a command, check the busy window (R3) and the command word.
  task automatic cmd(input logic [31:0] d, input string req);
    logic [31:0] v;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    r_cmd = {d[31:8], r_cmd[7:6], d[5:0]};
    if (d[1:0] != 2'b00) begin
      chk("R3", "busy cycle 1", {31'b0, busy}, 32'd1);
      rd(4'd1, v);
      chk("R3", "op field during busy", {30'b0, v[1:0]}, {30'b0, d[1:0]});
      @(negedge clk);
      chk("R3", "busy cycle 2", {31'b0, busy}, 32'd1);
      @(negedge clk);
      chk("R3", "busy after completion", {31'b0, busy}, 32'd0);
      model_op();
    end
    rd(4'd1, v);
    chk(req, "command word", v, exp_cmd());
  endtask

  task automatic chk_result(input string req);
    logic [31:0] v;
    rd(4'd8,  v); chk(req, "result hash",  v, x_h);
    rd(4'd9,  v); chk(req, "result ctl",   v, x_c);
    rd(4'd10, v); chk(req, "result src",   v, x_s);
    rd(4'd11, v); chk(req, "result dst",   v, x_d);
    rd(4'd12, v); chk(req, "result ports", v, x_p);
    rd(4'd13, v); chk(req, "result flex",  v, x_f);
  endtask

  function automatic logic [31:0] hw(input bit vld, input logic [15:0] sig,
                                     input logic [3:0] b);
    return {vld, 7'h00, sig, 4'h0, b};
  endfunction

  // command word: op, upd, last, qen, drop, ftype, queue, pool
  function automatic logic [31:0] cw(input logic [1:0] op, input bit upd,
                                     input bit last, input bit qen, input bit drop,
                                     input logic [1:0] ft, input logic [6:0] q,
                                     input logic [5:0] pool);
    return {9'h000, pool, q, ft, 2'b00, drop, qen, last, upd, op};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1", "busy after reset", {31'b0, busy}, 32'd0);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk("R1", "register after reset", v, 32'h0);
    end

    // R9 perfect-mode add, R4 query readback
    wr(4'd6, 32'h0000_0015);               // perfect, drop queue 10
    wr(4'd2, 32'hC0A8_0001);
    wr(4'd3, 32'h0A00_0002);
    wr(4'd4, 32'h0050_1F90);
    wr(4'd5, 32'h0011_BEEF);
    wr(4'd0, hw(1'b1, 16'h1234, 4'd3));
    cmd(cw(2'd1, 0, 1, 1, 0, 2'd2, 7'd33, 6'd5), "R4");
    cmd(cw(2'd2, 0, 0, 0, 0, 2'd0, 7'd0, 6'd0), "R4");
    chk("R4", "found after add", x_c, {9'h000, 6'd5, 7'd33, 2'd2, 3'b000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1});
    chk_result("R9");

    // R7: signature mismatch in the same slot
    wr(4'd0, hw(1'b1, 16'h4321, 4'd3));
    cmd(cw(2'd2, 0, 0, 0, 0, 2'd0, 7'd0, 6'd0), "R7");
    chk_result("R7");

    // R5: invalid hash word
    wr(4'd0, hw(1'b0, 16'h0077, 4'd5));
    cmd(cw(2'd1, 1, 0, 0, 0, 2'd1, 7'd9, 6'd1), "R5");
    wr(4'd0, hw(1'b1, 16'h0077, 4'd5));
    cmd(cw(2'd2, 0, 0, 0, 0, 2'd0, 7'd0, 6'd0), "R5");
    chk_result("R5");

    // R6: occupied slot, update clear then set
    wr(4'd0, hw(1'b1, 16'h1234, 4'd3));
    cmd(cw(2'd1, 0, 0, 0, 0, 2'd1, 7'd2, 6'd2), "R6");
    cmd(cw(2'd2, 0, 0, 0, 0, 2'd0, 7'd0, 6'd0), "R6");
    chk_result("R6");
    cmd(cw(2'd1, 1, 0, 1, 0, 2'd1, 7'd2, 6'd2), "R6");
    cmd(cw(2'd2, 0, 0, 0, 0, 2'd0, 7'd0, 6'd0), "R6");
    chk_result("R6");

    // R8: remove gated by found
    wr(4'd0, hw(1'b1, 16'h0099, 4'd7));
    cmd(cw(2'd2, 0, 0, 0, 0, 2'd0, 7'd0, 6'd0), "R8");
    wr(4'd0, hw(1'b1, 16'h1234, 4'd3));
    cmd(cw(2'd3, 0, 0, 0, 0, 2'd0, 7'd0, 6'd0), "R8");
    cmd(cw(2'd2, 0, 0, 0, 0, 2'd0, 7'd0, 6'd0), "R8");
    cmd(cw(2'd3, 0, 0, 0, 0, 2'd0, 7'd0, 6'd0), "R8");
    cmd(cw(2'd2, 0, 0, 0, 0, 2'd0, 7'd0, 6'd0), "R8");
    chk_result("R8");

    // R10: drop in perfect mode uses drop queue; refused in signature mode
    wr(4'd0, hw(1'b1, 16'h00AA, 4'd9));
    cmd(cw(2'd1, 0, 0, 1, 1, 2'd3, 7'd100, 6'd7), "R10");
    cmd(cw(2'd2, 0, 0, 0, 0, 2'd0, 7'd0, 6'd0), "R10");
    chk("R10", "drop queue field", {25'b0, x_c[16:10]}, 32'd10);
    wr(4'd6, 32'h0000_0014);               // signature mode
    wr(4'd0, hw(1'b1, 16'h00AB, 4'd10));
    cmd(cw(2'd1, 0, 0, 1, 1, 2'd3, 7'd100, 6'd7), "R10");
    chk("R10", "drop refused error", {31'b0, m_err}, 32'd1);

    // R9: signature mode stores zero address fields
    cmd(cw(2'd1, 0, 0, 1, 0, 2'd0, 7'd4, 6'd0), "R9");
    cmd(cw(2'd2, 0, 0, 0, 0, 2'd0, 7'd0, 6'd0), "R9");
    chk_result("R9");

    // R11: writes during the busy window are ignored
    wr(4'd0, hw(1'b1, 16'h0505, 4'd12));
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd1; wr_data = cw(2'd1, 0, 0, 0, 0, 2'd1, 7'd6, 6'd1);
    @(negedge clk);
    r_cmd = {wr_data[31:8], r_cmd[7:6], wr_data[5:0]};
    wr_addr = 4'd0; wr_data = hw(1'b1, 16'hFFFF, 4'd1);
    @(negedge clk);
    wr_addr = 4'd1; wr_data = cw(2'd2, 1, 1, 1, 1, 2'd3, 7'd127, 6'd63);
    @(negedge clk);
    wr_en = 1'b0;
    model_op();
    chk("R11", "busy after window", {31'b0, busy}, 32'd0);
    rd(4'd0, v); chk("R11", "hash kept", v, r_hash);
    rd(4'd1, v); chk("R11", "command kept", v, exp_cmd());
    cmd(cw(2'd2, 0, 0, 0, 0, 2'd0, 7'd0, 6'd0), "R11");
    chk_result("R11");

    // R2: zero-op command only stores fields
    cmd(cw(2'd0, 1, 0, 1, 0, 2'd2, 7'd55, 6'd9), "R2");
    chk("R2", "idle after zero op", {31'b0, busy}, 32'd0);

    // R12: flush in the middle of an add
    wr(4'd0, hw(1'b1, 16'h0606, 4'd13));
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd1; wr_data = cw(2'd1, 0, 0, 0, 0, 2'd0, 7'd1, 6'd0);
    @(negedge clk);
    r_cmd = {wr_data[31:8], r_cmd[7:6], wr_data[5:0]};
    wr_en = 1'b0; flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    model_flush();
    chk("R12", "busy after flush", {31'b0, busy}, 32'd0);
    rd(4'd1, v); chk("R12", "command after flush", v, exp_cmd());
    chk_result("R12");
    cmd(cw(2'd2, 0, 0, 0, 0, 2'd0, 7'd0, 6'd0), "R12");
    chk("R12", "flushed slot not found", {31'b0, m_found}, 32'd0);
    // flush together with a command write
    wr(4'd0, hw(1'b1, 16'h0101, 4'd2));
    cmd(cw(2'd1, 0, 0, 0, 0, 2'd0, 7'd3, 6'd0), "R12");
    @(negedge clk);
    flush = 1'b1; wr_en = 1'b1; wr_addr = 4'd1;
    wr_data = cw(2'd1, 1, 1, 1, 0, 2'd3, 7'd77, 6'd3);
    @(negedge clk);
    flush = 1'b0; wr_en = 1'b0;
    model_flush();
    chk("R12", "no start with flush", {31'b0, busy}, 32'd0);
    rd(4'd1, v); chk("R12", "write dropped with flush", v, exp_cmd());
    cmd(cw(2'd2, 0, 0, 0, 0, 2'd0, 7'd0, 6'd0), "R12");
    chk_result("R12");

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [31:0] d;
      logic [15:0] sig;
      int unsigned sel;
      sel = $urandom % 8;
      if (sel == 0) wr(4'd6, $urandom);
      if (sel == 1) begin
        wr(4'd2, $urandom); wr(4'd3, $urandom);
        wr(4'd4, $urandom); wr(4'd5, $urandom);
      end
      sig = 16'($urandom % 3);
      wr(4'd0, {($urandom % 10) != 0, 7'($urandom), sig, 4'($urandom),
                4'($urandom % 6)});
      d = $urandom;
      d[1:0] = 2'(1 + ($urandom % 3));
      if (d[1:0] == 2'd1) cmd(d, "R6");
      else if (d[1:0] == 2'd2) begin
        cmd(d, "R7");
        chk_result("R7");
      end else cmd(d, "R8");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule